// File: doc/BRIEF.md
# Indirect Register Access Port

This block puts a bank of 16-bit internal registers behind a small window of directly addressed host registers. The window has a status register, an address register and four 32-bit data holding registers. To write, the host loads the holding registers and then writes the address register. To read, the host writes the address register with the read flag set and picks up the result from the first holding register. Every transfer is started by the address write. It then runs for a fixed number of cycles, and during that time a busy bit in the status register is set. The host polls that bit until it clears.

A 32-bit quantity occupies an even/odd pair of internal words. A transfer to an even address writes the low half from holding register 0 and the high half from holding register 1 into the word pair. Reading it back takes two 16-bit reads, one at the even address and one at the odd address. The status register also controls the internal bank's reset. Clearing the run bit holds every internal word at zero. Setting the run bit releases the bank.

Host registers are selected by `host_sel`: 0 status, 1 address, 2 to 5 holding registers 0 to 3. Status fields are bit 0 busy, bit 1 run and bit 2 error. In the address register, bit 7 is the direction flag (1 = read, 0 = write) and the low bits index the internal bank.

Top module: `ind_reg_port`

## Requirements
- R1: After reset, the status, address and all four holding registers read as zero, and the internal bank is held in reset.
- R2: A write transfer to an even internal address A stores bits 15:0 of holding register 0 in word A and bits 15:0 of holding register 1 in word A+1.
- R3: A write transfer to an odd internal address stores only holding register 0 bits 15:0 in that word. Neighbouring words keep their values.
- R4: A read transfer (address bit 7 set) replaces holding register 0 with the selected word in bits 15:0 and zero in bits 31:16, whatever the register held before.
- R5: Status bit 0 is set from the cycle after an accepted address write and stays set for exactly BUSY_CYCLES cycles. The transfer takes effect in the cycle it clears.
- R6: An address write that arrives while busy is set is ignored. The address register and the bank do not change, and the sticky error bit (status bit 2) is set. It stays set until the next status register write.
- R7: Writing status with bit 1 clear holds every internal word at zero. While held, reads return zero and writes are lost. Writing bit 1 set releases the bank. Status bit 1 reads back the last value written.
- R8: Only the low log2(DEPTH) bits of the address select an internal word. Higher index bits alias.
- R9: Holding registers 2 and 3 keep full 32-bit host values that read back unchanged, and they have no effect on any internal word.
- R10: A host read returns its data on `host_rdata` with `host_rvalid` high in the cycle after the request, and `host_rvalid` is low otherwise. Selects 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_valid | input | 1 | Host request strobe, one request per cycle |
| host_write | input | 1 | 1 = write request, 0 = read request |
| host_sel | input | 3 | Host register select |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read response strobe, one cycle after a read request |

## Verification
The assertions rely on the host raising `host_valid` for single cycles with `host_sel`, `host_write` and `host_wdata` known whenever it is high. They also rely on DEPTH being a power of two, so that the odd partner of an even word always exists. The bench changes every input on the falling clock edge and issues at most one request per cycle. It holds reset for several cycles before the first request. It only relies on overlapping an address write with a busy transfer in the scenario that tests the rejection.

// File: rtl/irp_pkg.sv
// Package: shared constants for the indirect register access port.
// Assumes a 3-bit host select and an 8-bit internal address with the
// direction flag in its top bit.
package irp_pkg;
    localparam int SEL_W   = 3;
    localparam int HOST_DW = 32;
    localparam int WORD_W  = 16;
    localparam int IADR_W  = 8;
    localparam int DIR_POS = 7;

    // host register selects
    localparam logic [SEL_W-1:0] SEL_STAT = 3'd0;
    localparam logic [SEL_W-1:0] SEL_ADDR = 3'd1;
    localparam logic [SEL_W-1:0] SEL_D0   = 3'd2;
    localparam logic [SEL_W-1:0] SEL_D1   = 3'd3;
    localparam logic [SEL_W-1:0] SEL_D2   = 3'd4;
    localparam logic [SEL_W-1:0] SEL_D3   = 3'd5;

    // status field positions
    localparam int ST_BUSY = 0;
    localparam int ST_RUN  = 1;
    localparam int ST_ERR  = 2;

    localparam int N_HOLD = 4;
endpackage

// File: rtl/irp_host_if.sv
// Module: host register window. Decodes single-cycle host requests, keeps
// the holding registers and the run bit, and returns registered read data.
// Assumes host_valid is high for at most one request per cycle.
module irp_host_if
    import irp_pkg::*;
#(
    parameter int DW = HOST_DW,
    parameter int WW = WORD_W,
    parameter int AW = IADR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_valid,
    input  logic             host_write,
    input  logic [SEL_W-1:0] host_sel,
    input  logic [DW-1:0]    host_wdata,
    input  logic             xfer_busy,
    input  logic             xfer_err,
    input  logic [AW-1:0]    xfer_addr,
    input  logic             rd_load,
    input  logic [WW-1:0]    rd_word,
    output logic [DW-1:0]    host_rdata,
    output logic             host_rvalid,
    output logic             addr_wr,
    output logic [AW-1:0]    addr_val,
    output logic             stat_wr,
    output logic             bank_run,
    output logic [WW-1:0]    lo_word,
    output logic [WW-1:0]    hi_word
);
    logic          wr_acc;
    logic          rd_acc;
    logic [DW-1:0] hold_q [N_HOLD];
    logic [DW-1:0] stat_word;
    logic [DW-1:0] rd_mux;

    assign wr_acc   = host_valid && host_write;
    assign rd_acc   = host_valid && !host_write;
    assign addr_wr  = wr_acc && (host_sel == SEL_ADDR);
    assign addr_val = host_wdata[AW-1:0];
    assign stat_wr  = wr_acc && (host_sel == SEL_STAT);
    assign lo_word  = hold_q[0][WW-1:0];
    assign hi_word  = hold_q[1][WW-1:0];

    // Holding registers: host writes, read completion replaces register 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_HOLD; i++) hold_q[i] <= '0;
        end else begin
            for (int i = 0; i < N_HOLD; i++) begin
                if (i == 0 && rd_load)
                    hold_q[i] <= DW'(rd_word);
                else if (wr_acc && host_sel == SEL_W'(int'(SEL_D0) + i))
                    hold_q[i] <= host_wdata;
            end
        end
    end

    // Run bit: follows bit ST_RUN of every status write
    always_ff @(posedge clk) begin
        if (!rst_n)      bank_run <= 1'b0;
        else if (stat_wr) bank_run <= host_wdata[ST_RUN];
    end

    // Status word assembly
    always_comb begin
        stat_word          = '0;
        stat_word[ST_BUSY] = xfer_busy;
        stat_word[ST_RUN]  = bank_run;
        stat_word[ST_ERR]  = xfer_err;
    end

    // Read multiplexer over the host window
    always_comb begin
        case (host_sel)
            SEL_STAT: rd_mux = stat_word;
            SEL_ADDR: rd_mux = DW'(xfer_addr);
            SEL_D0:   rd_mux = hold_q[0];
            SEL_D1:   rd_mux = hold_q[1];
            SEL_D2:   rd_mux = hold_q[2];
            SEL_D3:   rd_mux = hold_q[3];
            default:  rd_mux = '0;
        endcase
    end

    // Registered read response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata  <= '0;
            host_rvalid <= 1'b0;
        end else begin
            host_rvalid <= rd_acc;
            if (rd_acc) host_rdata <= rd_mux;
        end
    end

    // R10
    rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> host_rvalid);
    // R10
    rvalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> !host_rvalid);
endmodule

// File: rtl/irp_xfer_seq.sv
// Module: transfer sequencer. Accepts an address write when idle, holds
// busy for BUSY_CYCLES cycles, pulses done on the last one and keeps a
// sticky error for address writes that arrive while busy.
// Assumes BUSY_CYCLES >= 1.
module irp_xfer_seq #(
    parameter int BUSY_CYCLES = 4,
    parameter int AW          = 8,
    parameter int DIR_BIT     = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic          err_clr,
    output logic          busy,
    output logic          done,
    output logic          is_read,
    output logic [AW-1:0] cur_addr,
    output logic          err
);
    localparam int              CNT_W    = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             accept;
    logic             reject;

    assign accept  = start && !busy;
    assign reject  = start && busy;
    assign done    = busy && (cnt_q == '0);
    assign is_read = cur_addr[DIR_BIT];

    // Busy window counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (accept) begin
            busy  <= 1'b1;
            cnt_q <= CNT_LOAD;
        end else if (done) begin
            busy  <= 1'b0;
        end else if (busy) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Address register: captured only for accepted starts
    always_ff @(posedge clk) begin
        if (!rst_n)      cur_addr <= '0;
        else if (accept) cur_addr <= start_addr;
    end

    // Sticky collision flag, cleared by a status write
    always_ff @(posedge clk) begin
        if (!rst_n)       err <= 1'b0;
        else if (reject)  err <= 1'b1;
        else if (err_clr) err <= 1'b0;
    end

    // R5
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && cur_addr == $past(start_addr)));
    // R5
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R6
    start_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> (err && $stable(cur_addr)));
    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !err_clr) |=> err);
endmodule

// File: rtl/irp_reg_bank.sv
// Module: internal word bank. DEPTH words of WW bits with an even/odd pair
// write, a combinational read and a hold-in-reset input.
// Assumes DEPTH is a power of two of at least 2.
module irp_reg_bank #(
    parameter int DEPTH = 16,
    parameter int WW    = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [WW-1:0]            wr_lo,
    input  logic [WW-1:0]            wr_hi,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [WW-1:0]            rd_data
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [DEPTH-1:0][WW-1:0] words;
    logic                     pair_en;
    logic [IDX_W-1:0]         partner;

    assign pair_en = !wr_idx[0];
    assign partner = wr_idx | IDX_W'(1);
    assign rd_data = words[rd_idx];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_word
            logic [WW-1:0] q;
            // One word: cleared while held, else lo or pair-hi write
            always_ff @(posedge clk) begin
                if (!rst_n || !run)
                    q <= '0;
                else if (wr_en && wr_idx == IDX_W'(g))
                    q <= wr_lo;
                else if (wr_en && pair_en && partner == IDX_W'(g))
                    q <= wr_hi;
            end
            assign words[g] = q;
        end
    endgenerate

    // R7
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (rd_data == '0));
    // R2
    write_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && run) |=> (words[$past(wr_idx)] == $past(wr_lo)));
endmodule

// File: rtl/ind_reg_port.sv
// Module: indirect register access port top. Connects the host window,
// the transfer sequencer and the internal bank.
// Assumes DEPTH is a power of two no larger than 128.
module ind_reg_port
    import irp_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int BUSY_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_valid,
    input  logic               host_write,
    input  logic [SEL_W-1:0]   host_sel,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    output logic               host_rvalid
);
    localparam int IDX_W = $clog2(DEPTH);

    logic              addr_wr;
    logic [IADR_W-1:0] addr_val;
    logic              stat_wr;
    logic              bank_run;
    logic [WORD_W-1:0] lo_word;
    logic [WORD_W-1:0] hi_word;
    logic              busy;
    logic              done;
    logic              is_read;
    logic [IADR_W-1:0] cur_addr;
    logic              err;
    logic [WORD_W-1:0] rd_word;
    logic [IDX_W-1:0]  idx;

    assign idx = cur_addr[IDX_W-1:0];

    irp_host_if #(.DW(HOST_DW), .WW(WORD_W), .AW(IADR_W)) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_valid (host_valid),
        .host_write (host_write),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .xfer_busy  (busy),
        .xfer_err   (err),
        .xfer_addr  (cur_addr),
        .rd_load    (done && is_read),
        .rd_word    (rd_word),
        .host_rdata (host_rdata),
        .host_rvalid(host_rvalid),
        .addr_wr    (addr_wr),
        .addr_val   (addr_val),
        .stat_wr    (stat_wr),
        .bank_run   (bank_run),
        .lo_word    (lo_word),
        .hi_word    (hi_word)
    );

    irp_xfer_seq #(.BUSY_CYCLES(BUSY_CYCLES), .AW(IADR_W), .DIR_BIT(DIR_POS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (addr_wr),
        .start_addr(addr_val),
        .err_clr   (stat_wr),
        .busy      (busy),
        .done      (done),
        .is_read   (is_read),
        .cur_addr  (cur_addr),
        .err       (err)
    );

    irp_reg_bank #(.DEPTH(DEPTH), .WW(WORD_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (bank_run),
        .wr_en  (done && !is_read),
        .wr_idx (idx),
        .wr_lo  (lo_word),
        .wr_hi  (hi_word),
        .rd_idx (idx),
        .rd_data(rd_word)
    );
endmodule

// File: tb/ind_reg_port_tb_top.sv
module ind_reg_port_tb_top;
    localparam int DEPTH = 16;
    localparam int BUSY  = 4;
    localparam logic [2:0] S_ST = 3'd0, S_AD = 3'd1, S_D0 = 3'd2,
                           S_D1 = 3'd3, S_D2 = 3'd4, S_D3 = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        valid;
    logic        write;
    logic [2:0]  sel;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        rvalid;
    logic        last_rv;
    int          n_chk = 0;
    int          n_bad = 0;

    always #5 clk = ~clk;

    ind_reg_port #(.DEPTH(DEPTH), .BUSY_CYCLES(BUSY)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_valid(valid), .host_write(write),
        .host_sel(sel), .host_wdata(wdata), .host_rdata(rdata), .host_rvalid(rvalid)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic hwr(input logic [2:0] s, input logic [31:0] d);
        valid = 1'b1; write = 1'b1; sel = s; wdata = d;
        @(negedge clk);
        valid = 1'b0; write = 1'b0;
    endtask

    task automatic hrd(input logic [2:0] s, output logic [31:0] d);
        valid = 1'b1; write = 1'b0; sel = s;
        @(negedge clk);
        valid = 1'b0;
        d = rdata; last_rv = rvalid;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 40; i++) begin
            hrd(S_ST, v);
            if (!v[0]) return;
        end
        check("R5 busy never cleared", 32'd1, 32'd0);
    endtask

    task automatic wr_ind(input logic [7:0] a, input logic [15:0] lo, input logic [15:0] hi);
        hwr(S_D0, {16'h0, lo}); hwr(S_D1, {16'h0, hi});
        hwr(S_D2, 32'h0); hwr(S_D3, 32'h0);
        hwr(S_AD, {24'h0, a});
        wait_idle();
    endtask

    task automatic rd_ind(input logic [7:0] a, output logic [31:0] d);
        hwr(S_AD, {24'h0, a | 8'h80});
        wait_idle();
        hrd(S_D0, d);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        hrd(S_ST, v); check("R1 status", v, 32'h0);
        hrd(S_AD, v); check("R1 addr", v, 32'h0);
        hrd(S_D0, v); check("R1 d0", v, 32'h0);
        hrd(S_D1, v); check("R1 d1", v, 32'h0);
        hrd(S_D2, v); check("R1 d2", v, 32'h0);
        hrd(S_D3, v); check("R1 d3", v, 32'h0);
        rd_ind(8'h01, v); check("R1 bank held", v, 32'h0);
    endtask

    task automatic t_release();
        logic [31:0] v;
        hwr(S_ST, 32'h2);
        hrd(S_ST, v); check("R7 run bit", v, 32'h2);
    endtask

    task automatic t_write_pair();
        logic [31:0] v;
        wr_ind(8'h04, 16'h1234, 16'hABCD);
        rd_ind(8'h04, v); check("R2 even lo", v, 32'h1234);
        rd_ind(8'h05, v); check("R2 even hi", v, 32'hABCD);
    endtask

    task automatic t_odd();
        logic [31:0] v;
        wr_ind(8'h07, 16'h5555, 16'h7777);
        rd_ind(8'h07, v); check("R3 odd word", v, 32'h5555);
        rd_ind(8'h08, v); check("R3 next untouched", v, 32'h0);
        rd_ind(8'h06, v); check("R3 prev untouched", v, 32'h0);
    endtask

    task automatic t_read_upper();
        logic [31:0] v;
        hwr(S_D0, 32'hFFFF_0000);
        hwr(S_AD, 32'h84);
        wait_idle();
        hrd(S_D0, v); check("R4 read clears upper", v, 32'h0000_1234);
    endtask

    task automatic t_busy();
        logic [31:0] v;
        hwr(S_AD, 32'h80);
        for (int i = 0; i < BUSY; i++) begin
            hrd(S_ST, v); check("R5 busy set", {31'h0, v[0]}, 32'h1);
        end
        hrd(S_ST, v); check("R5 busy cleared", {31'h0, v[0]}, 32'h0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        hwr(S_D0, 32'h1111); hwr(S_D1, 32'h2222);
        hwr(S_AD, 32'h06);
        hwr(S_AD, 32'h0C);
        wait_idle();
        hrd(S_AD, v); check("R6 addr kept", v, 32'h06);
        hrd(S_ST, v); check("R6 err set", v, 32'h6);
        rd_ind(8'h0C, v); check("R6 dropped write", v, 32'h0);
        rd_ind(8'h06, v); check("R6 first write", v, 32'h1111);
        hrd(S_ST, v); check("R6 err sticky", v, 32'h6);
        hwr(S_ST, 32'h2);
        hrd(S_ST, v); check("R6 err cleared", v, 32'h2);
    endtask

    task automatic t_alias();
        logic [31:0] v;
        wr_ind(8'h12, 16'h0A0A, 16'h0B0B);
        rd_ind(8'h02, v); check("R8 alias lo", v, 32'h0A0A);
        rd_ind(8'h03, v); check("R8 alias hi", v, 32'h0B0B);
    endtask

    task automatic t_holding();
        logic [31:0] v;
        hwr(S_D0, 32'h3333); hwr(S_D1, 32'h4444);
        hwr(S_D2, 32'hDEAD_0001); hwr(S_D3, 32'hBEEF_0002);
        hwr(S_AD, 32'h08);
        wait_idle();
        hrd(S_D2, v); check("R9 d2 readback", v, 32'hDEAD_0001);
        hrd(S_D3, v); check("R9 d3 readback", v, 32'hBEEF_0002);
        rd_ind(8'h08, v); check("R9 word lo", v, 32'h3333);
        rd_ind(8'h09, v); check("R9 word hi", v, 32'h4444);
        rd_ind(8'h0A, v); check("R9 no d2 effect", v, 32'h0);
        rd_ind(8'h0B, v); check("R9 no d3 effect", v, 32'h0);
    endtask

    task automatic t_hold();
        logic [31:0] v;
        hwr(S_ST, 32'h0);
        hrd(S_ST, v); check("R7 run cleared", v, 32'h0);
        rd_ind(8'h04, v); check("R7 held read", v, 32'h0);
        wr_ind(8'h04, 16'h9999, 16'h8888);
        hwr(S_ST, 32'h2);
        rd_ind(8'h04, v); check("R7 cleared lo", v, 32'h0);
        rd_ind(8'h05, v); check("R7 cleared hi", v, 32'h0);
    endtask

    task automatic t_rvalid();
        logic [31:0] v;
        hrd(S_D0, v); check("R10 rvalid high", {31'h0, last_rv}, 32'h1);
        @(negedge clk);
        check("R10 rvalid low", {31'h0, rvalid}, 32'h0);
        hrd(3'd6, v); check("R10 sel6 zero", v, 32'h0);
        hrd(3'd7, v); check("R10 sel7 zero", v, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; valid = 1'b0; write = 1'b0; sel = '0; wdata = '0; last_rv = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_release();
        t_write_pair();
        t_odd();
        t_read_upper();
        t_busy();
        t_collide();
        t_alias();
        t_holding();
        t_hold();
        t_rvalid();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule